// File: doc/BRIEF.md
# Primary-Rate TDM Frame Assembler

This block turns twenty-four parallel 8-bit voice channel samples into one serial primary-rate time-division stream. Each frame carries one full sample from every channel, sent in channel order and most significant bit first, followed by a single framing bit, for 193 bit slots per frame. At a frame rate of 8000 per second this gives the 1.544 Mb/s line rate. The block advances one bit slot per pulse of a bit-rate clock enable, so the surrounding logic sets the line rate with that enable.

Samples arrive through a write port that names a channel. They are held in a staging bank and copied into an active bank at the frame boundary, together with a 24-bit signaling vector. Mid-frame input changes therefore never disturb the frame in flight. A modulo-6 frame counter marks every sixth frame as a signaling frame. In that frame the least significant bit of each channel is replaced by that channel's signaling bit. The framing bit alternates 0,1 from frame to frame unless a configuration input forces a fixed value.

Top module: `tdm_frame_asm`

## Requirements
- R1: While the synchronous active-low reset rstN is low, and right after it is released, the outputs show slot 0: chanIdx 0, bitIdx 0, frameStart 1, sigFrame 0 and serOut 0. Both sample banks, the latched signaling vector, the frame counter and the framing toggle are cleared.
- R2: The bit slot moves by exactly one on each clock edge where bitEn is 1, and holds when bitEn is 0.
- R3: A frame is 193 slots. The channel slots come first, with chanIdx 0..23 and bitIdx 0..7 in each. The last slot is the framing slot, shown as chanIdx 24 and bitIdx 0. It is followed by slot 0 of the next frame. frameStart is 1 exactly in slot 0.
- R4: In the slot with chanIdx c and bitIdx k, serOut carries bit (7-k) of channel c's active sample, so samples go out MSB first.
- R5: A write with sampleLoad=1 stores sampleData into the staging entry of channel sampleCh. The active bank takes the whole staging bank on the edge that leaves the framing slot. A write made on that same edge goes to the next frame. The first frame after reset sends all-zero samples.
- R6: A write whose sampleCh is 24 or more changes no staging entry.
- R7: A frame counter counts modulo 6. It is 0 after reset and steps on the edge that leaves the framing slot. sigFrame is 1 exactly while the counter equals 5.
- R8: While sigFrame is 1, the bitIdx 7 slot of channel c carries bit c of the signaling vector latched at the last frame boundary, in place of the sample LSB.
- R9: With fixFrameBit at 0, the framing slot carries 0 in the first frame after reset, then 1, 0, 1 and so on. With fixFrameBit at 1, it carries fixFrameVal. The alternation keeps counting while it is overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitEn | input | 1 | Bit-rate enable; one slot per pulse |
| sampleLoad | input | 1 | Write strobe for the staging bank |
| sampleCh | input | 5 | Channel addressed by the write (0..23 valid) |
| sampleData | input | 8 | Companded sample to store |
| sigBits | input | 24 | Signaling bits, bit c for channel c |
| fixFrameBit | input | 1 | Force the framing bit value |
| fixFrameVal | input | 1 | Framing bit value used when forced |
| serOut | output | 1 | Serial line bit of the current slot |
| frameStart | output | 1 | High in the first slot of a frame |
| sigFrame | output | 1 | High during a signaling frame |
| chanIdx | output | 5 | Current channel slot (24 = framing slot) |
| bitIdx | output | 3 | Bit position within the channel slot |

## Verification
The serial output is first tried with random writes to valid channels made throughout the frame. This separates the behaviour of latching at the boundary from sending live values. A phase of writes that only address channels 24 to 31 shows whether out-of-range writes leak into the staging bank. A long run with a random enable and a changing signaling vector then spans several modulo-6 periods. It tells robbed-bit frames apart from plain frames and checks stalls against slot advance. Random toggling of the framing override separates the forced framing value from the alternation running underneath it.

// File: rtl/tdm_asm_pkg.sv
package tdm_asm_pkg;
  localparam int NUM_CH     = 24;
  localparam int SAMPLE_W   = 8;
  localparam int SIG_PERIOD = 6;
  localparam int CH_W       = $clog2(NUM_CH + 1);
  localparam int BIT_W      = $clog2(SAMPLE_W);
  localparam int FC_W       = $clog2(SIG_PERIOD);

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic             wrap;     // leaving framing slot on this edge
    logic             fbSlot;   // current slot is the framing slot
    logic             robSlot;  // current slot carries a signaling bit
    logic [CH_W-1:0]  ch;       // current channel slot
    logic [BIT_W-1:0] bitPos;   // bit position in slot
  } ctlStrobe_t;
endpackage

// File: rtl/tdm_asm_ctrl.sv
module tdm_asm_ctrl
  import tdm_asm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  output ctlStrobe_t       ctl,
  output logic             frameStart,
  output logic             sigFrame,
  output logic [CH_W-1:0]  chanIdx,
  output logic [BIT_W-1:0] bitIdx
);
  localparam logic [CH_W-1:0]  FRAME_CH = CH_W'(NUM_CH);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);
  localparam logic [FC_W-1:0]  SIG_PH   = FC_W'(SIG_PERIOD - 1);

  logic [CH_W-1:0]  chCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [FC_W-1:0]  frmCnt;
  logic             inFrameSlot;
  logic             atLastBit;

  assign inFrameSlot = (chCnt == FRAME_CH);
  assign atLastBit   = (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chCnt  <= '0;
      bitCnt <= '0;
      frmCnt <= '0;
    end else if (bitEn) begin
      if (inFrameSlot) begin
        chCnt  <= '0;
        bitCnt <= '0;
        frmCnt <= (frmCnt == SIG_PH) ? '0 : frmCnt + 1'b1;
      end else if (atLastBit) begin
        bitCnt <= '0;
        chCnt  <= chCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.wrap    = bitEn && inFrameSlot;
    ctl.fbSlot  = inFrameSlot;
    ctl.robSlot = (frmCnt == SIG_PH) && atLastBit && !inFrameSlot;
    ctl.ch      = chCnt;
    ctl.bitPos  = bitCnt;
  end

  assign frameStart = (chCnt == '0) && (bitCnt == '0);
  assign sigFrame   = (frmCnt == SIG_PH);
  assign chanIdx    = chCnt;
  assign bitIdx     = bitCnt;
endmodule

// File: rtl/tdm_asm_data.sv
module tdm_asm_data
  import tdm_asm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic                sampleLoad,
  input  logic [CH_W-1:0]     sampleCh,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [NUM_CH-1:0]   sigBits,
  input  logic                fixFrameBit,
  input  logic                fixFrameVal,
  output logic                serOut
);
  localparam logic [BIT_W-1:0] MSB_POS = BIT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] stage [NUM_CH];
  logic [SAMPLE_W-1:0] act   [NUM_CH];
  logic [NUM_CH-1:0]   actSig;
  logic [NUM_CH-1:0]   ldHit;
  logic                fbTog;
  logic [CH_W-1:0]     chSafe;
  logic [BIT_W-1:0]    selBit;

  // per-channel write decode; out-of-range addresses hit nothing
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign ldHit[g] = sampleLoad && (sampleCh == CH_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        stage[i] <= '0;
        act[i]   <= '0;
      end
      actSig <= '0;
      fbTog  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctl.wrap)  act[i]   <= stage[i];
        if (ldHit[i])  stage[i] <= sampleData;
      end
      if (ctl.wrap) begin
        actSig <= sigBits;
        fbTog  <= ~fbTog;
      end
    end
  end

  assign chSafe = ctl.fbSlot ? '0 : ctl.ch;
  assign selBit = MSB_POS - ctl.bitPos;

  always_comb begin
    if (ctl.fbSlot)
      serOut = fixFrameBit ? fixFrameVal : fbTog;
    else if (ctl.robSlot)
      serOut = actSig[chSafe];
    else
      serOut = act[chSafe][selBit];
  end
endmodule

// File: rtl/tdm_frame_asm.sv
module tdm_frame_asm
  import tdm_asm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitEn,
  input  logic                sampleLoad,
  input  logic [CH_W-1:0]     sampleCh,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [NUM_CH-1:0]   sigBits,
  input  logic                fixFrameBit,
  input  logic                fixFrameVal,
  output logic                serOut,
  output logic                frameStart,
  output logic                sigFrame,
  output logic [CH_W-1:0]     chanIdx,
  output logic [BIT_W-1:0]    bitIdx
);
  ctlStrobe_t ctl;

  tdm_asm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .ctl        (ctl),
    .frameStart (frameStart),
    .sigFrame   (sigFrame),
    .chanIdx    (chanIdx),
    .bitIdx     (bitIdx)
  );

  tdm_asm_data u_data (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sampleLoad  (sampleLoad),
    .sampleCh    (sampleCh),
    .sampleData  (sampleData),
    .sigBits     (sigBits),
    .fixFrameBit (fixFrameBit),
    .fixFrameVal (fixFrameVal),
    .serOut      (serOut)
  );
endmodule

// File: rtl/tdm_asm_chk.sv
module tdm_asm_chk
  import tdm_asm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             bitEn,
  input logic             fixFrameBit,
  input logic             fixFrameVal,
  input logic             serOut,
  input logic             frameStart,
  input logic             sigFrame,
  input logic [CH_W-1:0]  chanIdx,
  input logic [BIT_W-1:0] bitIdx
);
  localparam logic [CH_W-1:0] FRAME_CH = CH_W'(NUM_CH);

  // R2
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(chanIdx) && $stable(bitIdx)));

  // R3
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && chanIdx == FRAME_CH) |=> frameStart);

  // R3
  frame_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanIdx == FRAME_CH) |-> (bitIdx == '0 && !frameStart));

  // R7
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bitEn && chanIdx == FRAME_CH) |=> $stable(sigFrame));

  // R7
  sig_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && chanIdx == FRAME_CH && sigFrame) |=> !sigFrame);

  // R9
  fix_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fixFrameBit && chanIdx == FRAME_CH) |-> (serOut == fixFrameVal));
endmodule

bind tdm_frame_asm tdm_asm_chk u_chk (.*);

// File: tb/tdm_frame_asm_test.sv
`timescale 1ns/1ps
module tdm_frame_asm_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        sampleLoad = 1'b0;
  logic [4:0]  sampleCh = '0;
  logic [7:0]  sampleData = '0;
  logic [23:0] sigBits = '0;
  logic        fixFrameBit = 1'b0;
  logic        fixFrameVal = 1'b0;
  logic        serOut, frameStart, sigFrame;
  logic [4:0]  chanIdx;
  logic [2:0]  bitIdx;

  int tests = 0;
  int fails = 0;

  // bench model
  logic [7:0]  mStage [24];
  logic [7:0]  mAct   [24];
  logic [23:0] mSig;
  int          mPos, mFrm, nFrames;
  logic        mFb;
  string       phaseTag = "";

  tdm_frame_asm uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int actv, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (pos %0d frame %0d)",
               tag, what, actv, expv, mPos, nFrames);
    end
  endtask

  function automatic logic expSer();
    int c = mPos / 8;
    int b = mPos % 8;
    if (mPos == 192) return fixFrameBit ? fixFrameVal : mFb;
    if (mFrm == 5 && b == 7) return mSig[c];
    return mAct[c][7-b];
  endfunction

  function automatic string serTag();
    if (mPos == 192) return "R9";
    if (mFrm == 5 && mPos % 8 == 7) return "R8";
    return "R4";
  endfunction

  task automatic checkOutputs();
    int ec = mPos / 8;
    int eb = mPos % 8;
    chk(chanIdx == 5'(ec), "R2 R3", "chanIdx", chanIdx, ec);
    chk(bitIdx == 3'(eb), "R2 R3", "bitIdx", bitIdx, eb);
    chk(frameStart == (mPos == 0), "R3", "frameStart", frameStart, int'(mPos == 0));
    chk(sigFrame == (mFrm == 5), "R7", "sigFrame", sigFrame, int'(mFrm == 5));
    chk(serOut == expSer(), {serTag(), phaseTag}, "serOut", serOut, expSer());
  endtask

  task automatic modelAdvance(input logic en, input logic ld,
                              input logic [4:0] ch, input logic [7:0] d);
    if (en) begin
      if (mPos == 192) begin
        for (int i = 0; i < 24; i++) mAct[i] = mStage[i];
        mSig = sigBits;
        mFrm = (mFrm + 1) % 6;
        mFb  = ~mFb;
        mPos = 0;
        nFrames++;
      end else begin
        mPos++;
      end
    end
    if (ld && ch < 24) mStage[ch] = d;
  endtask

  task automatic doStep(input logic en, input logic ld,
                        input logic [4:0] ch, input logic [7:0] d);
    bitEn = en; sampleLoad = ld; sampleCh = ch; sampleData = d;
    @(negedge clk);
    modelAdvance(en, ld, ch, d);
    checkOutputs();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 24; i++) begin mStage[i] = '0; mAct[i] = '0; end
    mSig = '0; mPos = 0; mFrm = 0; mFb = 1'b0; nFrames = 0;

    repeat (3) @(negedge clk);
    // R1: state under reset, then just after release
    chk(frameStart == 1'b1 && chanIdx == 0 && bitIdx == 0, "R1", "slot0 in reset",
        {frameStart, chanIdx, bitIdx}, 32'h100);
    rstN = 1'b1;
    @(negedge clk);
    chk(sigFrame == 1'b0, "R1", "sigFrame after reset", sigFrame, 0);
    chk(serOut == 1'b0, "R1", "serOut after reset", serOut, 0);
    checkOutputs();

    // R5: writes to valid channels all through the frame; first frame is zeros
    phaseTag = " R5";
    while (nFrames < 3)
      doStep(1'b1, 1'($urandom_range(1, 0)), 5'($urandom_range(23, 0)),
             8'($urandom_range(255, 0)));

    // R6: only out-of-range writes; frames must repeat the staged values
    phaseTag = " R6";
    while (nFrames < 5)
      doStep(1'b1, 1'b1, 5'($urandom_range(31, 24)), 8'($urandom_range(255, 0)));

    // directed stall: enable low must hold the slot (R2)
    phaseTag = " R2";
    repeat (6) doStep(1'b0, 1'b0, 5'd0, 8'd0);

    // random mix: stalls, writes anywhere, signaling and framing override (R7 R8 R9)
    phaseTag = "";
    while (nFrames < 16) begin
      if ($urandom_range(15, 0) == 0) sigBits = 24'($urandom());
      if ($urandom_range(99, 0) == 0) begin
        fixFrameBit = 1'($urandom_range(1, 0));
        fixFrameVal = 1'($urandom_range(1, 0));
      end
      doStep(1'($urandom_range(3, 0) != 0), 1'($urandom_range(1, 0)),
             5'($urandom_range(31, 0)), 8'($urandom_range(255, 0)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule